// File: doc/BRIEF.md
# Bank-Select Read Address Pointer

This block holds the byte address pointer and the active bank bit of a 4-Kbit serial EEPROM. The array is treated as two 256-byte banks, and only one of them is visible at a time. The block sits behind an I2C slave front end that has already decoded bus activity into single-cycle events:

- an address byte to load
- a byte sent to the master, with the master's ACK or NoACK
- a STOP
- the two bank-select commands
- the bank-query command

The block puts out the full array address as the bank bit above the 8-bit pointer. The storage array uses this address for reads.

An immediate read starts from whatever the pointer already holds. A selective read first loads the pointer with the address byte of a write that carries no data, then reads from there. Each byte sent advances the pointer. At the top of a bank the pointer wraps to the bottom of the same bank and never crosses into the other one. The block also tracks whether the master wants more data. It flags the end of a read when a NoACK is followed by a STOP, and it answers a bank query with the bank that was active when the query arrived.

Top module: `spd_bank_ptr`

## Requirements
- R1: After reset the pointer is 0x00 and the lower bank (bank bit 0) is active. rd_addr_o, bank_o, more_o, rd_done_o and bank_rsp_vld_o are all 0.
- R2: A cycle with addr_load_i high loads addr_byte_i into the pointer and leaves the bank unchanged. From the next cycle, rd_addr_o equals {bank_o, addr_byte_i}.
- R3: A cycle with byte_sent_i high (and addr_load_i low) adds one to the pointer. STOP and idle cycles keep the pointer, so the next immediate read starts where the last one ended.
- R4: An increment from pointer 0xFF gives 0x00 and leaves bank_o as it was, so the address wraps inside the active bank.
- R5: set_upper_i alone makes bank_o 1, and set_lower_i alone makes it 0. Both high together leave the bank unchanged. Neither command alters the pointer.
- R6: One cycle after query_bank_i, bank_rsp_vld_o is 1 for exactly one cycle. bank_rsp_o then carries the bank that was active before the query edge, even if a bank-select command arrived in the same cycle.
- R7: When addr_load_i and byte_sent_i are high in the same cycle, the load wins and the pointer takes addr_byte_i without the increment.
- R8: After a byte sent with master_ack_i = 1 (ACK), more_o is 1. After a byte sent with master_ack_i = 0 (NoACK), more_o is 0. stop_i or addr_load_i also clear more_o.
- R9: A stop_i that follows a NoACK byte, with no ACK byte or load in between, pulses rd_done_o for one cycle. A stop_i without a preceding NoACK does not pulse rd_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load pointer from addr_byte_i |
| addr_byte_i | input | PTR_W | Address byte received from the master |
| byte_sent_i | input | 1 | A read byte went out on the bus |
| master_ack_i | input | 1 | Master response to that byte: 1 = ACK, 0 = NoACK |
| stop_i | input | 1 | STOP condition seen |
| set_upper_i | input | 1 | Select the upper bank |
| set_lower_i | input | 1 | Select the lower bank |
| query_bank_i | input | 1 | Bank query command |
| rd_addr_o | output | PTR_W+1 | Array address {bank, pointer} |
| bank_o | output | 1 | Active bank, 1 = upper |
| more_o | output | 1 | Master acknowledged the last byte |
| rd_done_o | output | 1 | Read ended by NoACK then STOP |
| bank_rsp_vld_o | output | 1 | Bank query response valid |
| bank_rsp_o | output | 1 | Bank query response value |

## Verification
The bench builds the block with its default PTR_W of 8, so the array address is the 9-bit form of a 4-Kbit device. Loading the pointer near 0xFF brings the bank-edge wrap within two byte events, and this is done in both banks so that the bank bit can be seen to survive the wrap. With the real width, address values can be checked exactly as a host would see them, including the 0x1FF to 0x100 step in the upper bank.

// File: rtl/spd_ptr_pkg.sv
package spd_ptr_pkg;
  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;

  function automatic bank_e next_bank(bank_e cur, logic up, logic lo);
    if (up && !lo) return BANK_HI;
    if (lo && !up) return BANK_LO;
    return cur;
  endfunction
endpackage

// File: rtl/spd_bank_reg.sv
module spd_bank_reg
  import spd_ptr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  set_upper_i,
  input  logic  set_lower_i,
  input  logic  query_i,
  output bank_e bank_o,
  output logic  rsp_vld_o,
  output logic  rsp_o
);
  bank_e bank_q;
  logic  rsp_vld_q, rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q    <= BANK_LO;
      rsp_vld_q <= 1'b0;
      rsp_q     <= 1'b0;
    end else begin
      bank_q    <= next_bank(bank_q, set_upper_i, set_lower_i);
      rsp_vld_q <= query_i;
      // response reports bank before any same-cycle select
      if (query_i) rsp_q <= bank_q;
    end
  end

  assign bank_o    = bank_q;
  assign rsp_vld_o = rsp_vld_q;
  assign rsp_o     = rsp_q;
endmodule

// File: rtl/spd_byte_ptr.sv
module spd_byte_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] byte_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)      ptr_d = byte_i;
    else if (step_i) ptr_d = ptr_q + 1'b1; // natural wrap stays in bank
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/spd_rd_track.sv
module spd_rd_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic sent_i,
  input  logic ack_i,
  input  logic stop_i,
  output logic more_o,
  output logic done_o
);
  logic more_q, nack_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      more_q <= 1'b0;
      nack_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= stop_i & nack_q;
      if (load_i || stop_i) begin
        more_q <= 1'b0;
        nack_q <= 1'b0;
      end else if (sent_i) begin
        more_q <= ack_i;
        nack_q <= ~ack_i;
      end
    end
  end

  assign more_o = more_q;
  assign done_o = done_q;
endmodule

// File: rtl/spd_bank_ptr.sv
module spd_bank_ptr
  import spd_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_load_i,
  input  logic [PTR_W-1:0] addr_byte_i,
  input  logic             byte_sent_i,
  input  logic             master_ack_i,
  input  logic             stop_i,
  input  logic             set_upper_i,
  input  logic             set_lower_i,
  input  logic             query_bank_i,
  output logic [PTR_W:0]   rd_addr_o,
  output logic             bank_o,
  output logic             more_o,
  output logic             rd_done_o,
  output logic             bank_rsp_vld_o,
  output logic             bank_rsp_o
);
  localparam int unsigned AW = PTR_W + 1;

  bank_e            bank;
  logic [PTR_W-1:0] ptr;
  logic [AW-1:0]    addr;

  spd_bank_reg u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_upper_i (set_upper_i),
    .set_lower_i (set_lower_i),
    .query_i     (query_bank_i),
    .bank_o      (bank),
    .rsp_vld_o   (bank_rsp_vld_o),
    .rsp_o       (bank_rsp_o)
  );

  spd_byte_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_load_i),
    .byte_i (addr_byte_i),
    .step_i (byte_sent_i),
    .ptr_o  (ptr)
  );

  spd_rd_track u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_load_i),
    .sent_i (byte_sent_i),
    .ack_i  (master_ack_i),
    .stop_i (stop_i),
    .more_o (more_o),
    .done_o (rd_done_o)
  );

  assign addr      = {bank, ptr};
  assign rd_addr_o = addr;
  assign bank_o    = bank;
endmodule

// File: rtl/spd_bank_ptr_chk.sv
module spd_bank_ptr_chk #(
  parameter int unsigned PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             addr_load_i,
  input logic [PTR_W-1:0] addr_byte_i,
  input logic             byte_sent_i,
  input logic             master_ack_i,
  input logic             set_upper_i,
  input logic             set_lower_i,
  input logic             query_bank_i,
  input logic [PTR_W:0]   rd_addr_o,
  input logic             bank_o,
  input logic             more_o,
  input logic             rd_done_o,
  input logic             bank_rsp_vld_o,
  input logic             bank_rsp_o
);
  AST_LOAD_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_i |=> rd_addr_o[PTR_W-1:0] == $past(addr_byte_i)); // R2
  AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_sent_i && !addr_load_i) |=>
      rd_addr_o[PTR_W-1:0] == PTR_W'($past(rd_addr_o[PTR_W-1:0]) + 1'b1)); // R4
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_upper_i == set_lower_i) |=> $stable(bank_o)); // R5
  AST_BANK_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_upper_i && !set_lower_i) |=> bank_o); // R5
  AST_BANK_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_lower_i && !set_upper_i) |=> !bank_o); // R5
  AST_QUERY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_bank_i |=> (bank_rsp_vld_o && bank_rsp_o == $past(bank_o))); // R6
  AST_MORE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_sent_i && !addr_load_i) |=> more_o == $past(master_ack_i)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o); // R9
endmodule

bind spd_bank_ptr spd_bank_ptr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_load_i    (addr_load_i),
  .addr_byte_i    (addr_byte_i),
  .byte_sent_i    (byte_sent_i),
  .master_ack_i   (master_ack_i),
  .set_upper_i    (set_upper_i),
  .set_lower_i    (set_lower_i),
  .query_bank_i   (query_bank_i),
  .rd_addr_o      (rd_addr_o),
  .bank_o         (bank_o),
  .more_o         (more_o),
  .rd_done_o      (rd_done_o),
  .bank_rsp_vld_o (bank_rsp_vld_o),
  .bank_rsp_o     (bank_rsp_o)
);

// File: tb/sim_spd_bank_ptr.sv
module sim_spd_bank_ptr;
  localparam int unsigned PTR_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             addr_load_i = 1'b0;
  logic [PTR_W-1:0] addr_byte_i = '0;
  logic             byte_sent_i = 1'b0;
  logic             master_ack_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             set_upper_i = 1'b0;
  logic             set_lower_i = 1'b0;
  logic             query_bank_i = 1'b0;
  logic [PTR_W:0]   rd_addr_o;
  logic             bank_o, more_o, rd_done_o, bank_rsp_vld_o, bank_rsp_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spd_bank_ptr #(.PTR_W(PTR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_load_i(addr_load_i),
    .addr_byte_i(addr_byte_i), .byte_sent_i(byte_sent_i),
    .master_ack_i(master_ack_i), .stop_i(stop_i), .set_upper_i(set_upper_i),
    .set_lower_i(set_lower_i), .query_bank_i(query_bank_i),
    .rd_addr_o(rd_addr_o), .bank_o(bank_o), .more_o(more_o),
    .rd_done_o(rd_done_o), .bank_rsp_vld_o(bank_rsp_vld_o),
    .bank_rsp_o(bank_rsp_o)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // drive for one edge, then sample 1 ns after it
  task automatic step();
    @(posedge clk); #1;
    addr_load_i = 0; byte_sent_i = 0; master_ack_i = 0; stop_i = 0;
    set_upper_i = 0; set_lower_i = 0; query_bank_i = 0;
  endtask

  task automatic load(input int a);
    addr_load_i = 1; addr_byte_i = PTR_W'(a); step();
  endtask

  task automatic send(input bit ack);
    byte_sent_i = 1; master_ack_i = ack; step();
  endtask

  task automatic t_reset();
    chk("R1", "rd_addr", int'(rd_addr_o), 0);
    chk("R1", "bank", int'(bank_o), 0);
    chk("R1", "more", int'(more_o), 0);
    chk("R1", "done", int'(rd_done_o), 0);
    chk("R1", "rsp_vld", int'(bank_rsp_vld_o), 0);
  endtask

  task automatic t_seq_read();
    load('h3C);
    chk("R2", "load addr", int'(rd_addr_o), 'h03C);
    send(1); send(1); send(1);
    chk("R3", "after 3 acks", int'(rd_addr_o), 'h03F);
    chk("R8", "more after ack", int'(more_o), 1);
    send(0);
    chk("R8", "more after nack", int'(more_o), 0);
    chk("R3", "after nack byte", int'(rd_addr_o), 'h040);
    stop_i = 1; step();
    chk("R9", "done after nack+stop", int'(rd_done_o), 1);
    chk("R3", "kept over stop", int'(rd_addr_o), 'h040);
    step();
    chk("R9", "done one cycle", int'(rd_done_o), 0);
    step(); step();
    chk("R3", "kept while idle", int'(rd_addr_o), 'h040);
    send(1);
    chk("R3", "immediate read continues", int'(rd_addr_o), 'h041);
    stop_i = 1; step();
    chk("R9", "no done without nack", int'(rd_done_o), 0);
    chk("R8", "stop clears more", int'(more_o), 0);
  endtask

  task automatic t_bank();
    set_upper_i = 1; step();
    chk("R5", "upper bank", int'(bank_o), 1);
    chk("R5", "ptr kept on select", int'(rd_addr_o), 'h141);
    query_bank_i = 1; step();
    chk("R6", "rsp_vld", int'(bank_rsp_vld_o), 1);
    chk("R6", "rsp upper", int'(bank_rsp_o), 1);
    set_upper_i = 1; set_lower_i = 1; step();
    chk("R6", "rsp_vld single", int'(bank_rsp_vld_o), 0);
    chk("R5", "both selects hold", int'(bank_o), 1);
    set_lower_i = 1; query_bank_i = 1; step();
    chk("R5", "lower bank", int'(rd_addr_o), 'h041);
    chk("R6", "rsp old bank", int'(bank_rsp_o), 1);
    query_bank_i = 1; step();
    chk("R6", "rsp lower", int'(bank_rsp_o), 0);
  endtask

  task automatic t_wrap();
    set_upper_i = 1; step();
    load('hFE);
    chk("R2", "load in upper", int'(rd_addr_o), 'h1FE);
    send(1);
    chk("R4", "top of upper", int'(rd_addr_o), 'h1FF);
    send(1);
    chk("R4", "wrap in upper", int'(rd_addr_o), 'h100);
    set_lower_i = 1; step();
    load('hFF);
    send(1);
    chk("R4", "wrap in lower", int'(rd_addr_o), 'h000);
    chk("R4", "bank kept", int'(bank_o), 0);
  endtask

  task automatic t_prio();
    send(1);
    addr_load_i = 1; addr_byte_i = 'h10; byte_sent_i = 1; master_ack_i = 1; step();
    chk("R7", "load beats step", int'(rd_addr_o), 'h010);
    chk("R8", "load clears more", int'(more_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_seq_read();
    t_bank();
    t_wrap();
    t_prio();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule